// File: doc/BRIEF.md
# CPU Clock Mode Controller

This block chooses which oscillator drives the processor and by how much it is divided, and it guards every change of that choice. The main, sub and on-chip oscillators and the PLL output reach it as single-cycle tick strobes in one fast system clock domain. From the selected strobe the block produces one CPU clock-enable strobe. Software programs the block through a small write port with four registers: a selection register, an auxiliary register, a status register and a PLL register. Any of them can be read back through a separate read port.

Every write that would change the operating mode is checked against the permitted transitions before it is accepted. A refused write leaves all state untouched and sets a sticky error flag. Some bits are forced while both the main clock and the on-chip oscillator are off. When the main oscillator is restarted, switching onto it is held back for a programmable number of main ticks, and the previous source keeps clocking the CPU during that wait. A 3-bit output reports the mode that is actually in effect.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, the mode output is 1 and the CPU enable pulses once every 8 main ticks. The selection register (address 0) reads 0x08, the auxiliary register (address 1) reads 0x21, the status register (address 2) reads 0 and the PLL register (address 3) reads 0x04.
- R2: The selection register fields are: bit0 sub select, bit1 main stop, bit2 on-chip select, bit3 divide-by-8, bits5:4 divide field. With the main clock selected, a divide-by-8 bit of 1 gives /8 whatever the field holds. Otherwise the field gives 00→/1, 01→/2, 10→/4, 11→/16. The mode output is 0 at /1 and 1 for any other ratio.
- R3: A sub select of 1 makes the sub tick the undivided CPU clock. The mode is 3, or 4 once the main clock is stopped.
- R4: An on-chip select of 1 (with sub select 0) routes the on-chip tick through the same five ratios. The mode is 5, or 6 once the main clock is stopped.
- R5: PLL register bits are: bit0 enable, bit1 select, bit2 one-wait, bit3 fast (above 16 MHz). With enable and select both 1, the PLL tick clocks the CPU undivided and the mode is 2. PLL mode may be entered only from mode 0 and may be left only to mode 0.
- R6: While auxiliary bit1 (stop-detect enable) is 1, any write that would change the mode is refused.
- R7: A write that leaves on-chip mode for a main-clock mode is refused unless the divide-by-8 bit already reads 1.
- R8: While on-chip select is 0 and main stop is 1, divide-by-8 (address 0 bit3) and drive strength (address 1 bit0) both read and act as 1.
- R9: A write to address 3 that changes the one-wait bit while enable is 1 is refused. So is a write that turns enable on with fast=1 and one-wait=1.
- R10: A write to address 0 that changes both the divide field and divide-by-8 takes effect in two steps: the field in the write cycle, divide-by-8 one cycle later.
- R11: A refused write leaves all registers unchanged and sets status bit0. Writing 1 to that bit clears it. Setting main stop while the main path feeds the CPU is refused.
- R12: After main stop goes from 1 to 0, a selection that uses the main clock or the PLL takes effect only after the number of main ticks held in auxiliary bits7:2. Until then, the previous source and mode stay in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | Main oscillator tick strobe |
| sub_tick | input | 1 | Sub oscillator tick strobe |
| ring_tick | input | 1 | On-chip oscillator tick strobe |
| pll_tick | input | 1 | PLL output tick strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Read data (effective values) |
| cpu_ce | output | 1 | CPU clock-enable strobe |
| mode | output | 3 | Mode in effect |

## Verification
The assertions assume that every tick input is a clean one-cycle strobe and that main ticks keep arriving while the main oscillator restarts. They also assume that software never queues a second mode change while a stabilisation wait is pending, and never writes address 0 in the cycle right after a split write. The stimulus respects these limits. Tick strobes come from fixed cycle counters with distinct periods (main every 2 cycles, sub every 7, on-chip every 3, PLL every cycle), so each source can be identified from the pulse spacing. Writes are spaced several cycles apart, and the bench waits out each stabilisation window before the next selection change.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int STAB_RST = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       ring_tick,
  input  logic       pll_tick,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       cpu_ce,
  output logic [2:0] mode
);
  localparam int SW = 6;
  localparam logic [2:0] M_HIGH = 3'd0, M_MED = 3'd1, M_PLL = 3'd2, M_LOW = 3'd3,
                         M_LOWP = 3'd4, M_RING = 3'd5, M_RINGP = 3'd6;
  localparam logic [1:0] S_MAIN = 2'd0, S_SUB = 2'd1, S_RING = 2'd2, S_PLL = 2'd3;

  function automatic logic [2:0] mode_of(input logic sub, input logic off, input logic osc,
                                         input logic pll, input logic d8, input logic [1:0] fld);
    if (sub) return off ? M_LOWP : M_LOW;
    if (osc) return off ? M_RINGP : M_RING;
    if (pll) return M_PLL;
    return (d8 || fld != 2'b00) ? M_MED : M_HIGH;
  endfunction

  function automatic logic pll_bad(input logic [2:0] from_m, input logic [2:0] to_m);
    if ((from_m == M_PLL) == (to_m == M_PLL)) return 1'b0;
    return (from_m == M_PLL) ? (to_m != M_HIGH) : (from_m != M_HIGH);
  endfunction

  logic          sub_q, off_q, osc_q, div8_q, pend_q, pend_d;
  logic [1:0]    fld_q;
  logic          drv_q, sdet_q, err_q;
  logic [SW-1:0] stab_q, scnt_q;
  logic          pen_q, psel_q, pwait_q, pfast_q;
  logic [1:0]    act_src;
  logic [3:0]    act_last, cnt_q;
  logic [2:0]    act_mode;

  wire       forced   = ~osc_q & off_q;
  wire       d8_eff   = div8_q | forced;
  wire       drv_eff  = drv_q | forced;
  wire       pll_on   = pen_q & psel_q;
  wire [2:0] cur_mode = mode_of(sub_q, off_q, osc_q, pll_on, d8_eff, fld_q);

  wire       c0_d8   = wr_data[3] | (~wr_data[2] & wr_data[1]);
  wire [2:0] c0_mode = mode_of(wr_data[0], wr_data[1], wr_data[2], pll_on, c0_d8, wr_data[5:4]);
  wire [2:0] c3_mode = mode_of(sub_q, off_q, osc_q, wr_data[0] & wr_data[1], d8_eff, fld_q);

  wire bad0 = (sdet_q && c0_mode != cur_mode)
            || pll_bad(cur_mode, c0_mode)
            || (osc_q && !sub_q && !wr_data[2] && !wr_data[0] && !d8_eff)
            || (wr_data[1] && !wr_data[0] && !wr_data[2]);
  wire bad3 = (sdet_q && c3_mode != cur_mode)
            || pll_bad(cur_mode, c3_mode)
            || (pen_q && wr_data[2] != pwait_q)
            || (!pen_q && wr_data[0] && wr_data[3] && wr_data[2]);
  wire split0 = (wr_data[3] != div8_q) && (wr_data[5:4] != fld_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= 1'b0; off_q <= 1'b0; osc_q <= 1'b0; div8_q <= 1'b1; fld_q <= 2'b00;
      pend_q <= 1'b0; pend_d <= 1'b0;
      drv_q <= 1'b1; sdet_q <= 1'b0; stab_q <= SW'(STAB_RST);
      err_q <= 1'b0; scnt_q <= '0;
      pen_q <= 1'b0; psel_q <= 1'b0; pwait_q <= 1'b1; pfast_q <= 1'b0;
    end else begin
      if (pend_q) begin
        div8_q <= pend_d;
        pend_q <= 1'b0;
      end
      if (main_tick && scnt_q != '0) scnt_q <= scnt_q - 1'b1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            if (bad0) err_q <= 1'b1;
            else begin
              sub_q <= wr_data[0];
              off_q <= wr_data[1];
              osc_q <= wr_data[2];
              fld_q <= wr_data[5:4];
              if (split0) begin
                pend_q <= 1'b1;
                pend_d <= wr_data[3];
              end else div8_q <= wr_data[3];
              if (off_q && !wr_data[1]) scnt_q <= stab_q;
            end
          end
          2'd1: begin
            drv_q  <= wr_data[0];
            sdet_q <= wr_data[1];
            stab_q <= wr_data[7:2];
          end
          2'd2: if (wr_data[0]) err_q <= 1'b0;
          default: begin
            if (bad3) err_q <= 1'b1;
            else begin
              pen_q   <= wr_data[0];
              psel_q  <= wr_data[1];
              pwait_q <= wr_data[2];
              pfast_q <= wr_data[3];
            end
          end
        endcase
      end
    end
  end

  logic [3:0] ratio_last, new_last;
  logic [1:0] new_src;
  always_comb begin
    if (d8_eff) ratio_last = 4'd7;
    else begin
      case (fld_q)
        2'd0: ratio_last = 4'd0;
        2'd1: ratio_last = 4'd1;
        2'd2: ratio_last = 4'd3;
        default: ratio_last = 4'd15;
      endcase
    end
    if (sub_q) begin
      new_src = S_SUB;  new_last = 4'd0;
    end else if (osc_q) begin
      new_src = S_RING; new_last = ratio_last;
    end else if (pll_on) begin
      new_src = S_PLL;  new_last = 4'd0;
    end else begin
      new_src = S_MAIN; new_last = ratio_last;
    end
  end

  wire stab_busy = scnt_q != '0;
  wire need_main = (new_src == S_MAIN) || (new_src == S_PLL);
  wire act_en    = !stab_busy || !need_main;
  wire act_chg   = act_en && (new_src != act_src || new_last != act_last);

  logic tick;
  always_comb begin
    case (act_src)
      S_MAIN:  tick = main_tick;
      S_SUB:   tick = sub_tick;
      S_RING:  tick = ring_tick;
      default: tick = pll_tick;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_src <= S_MAIN; act_last <= 4'd7; act_mode <= M_MED; cnt_q <= 4'd0;
    end else begin
      if (act_en) begin
        act_src  <= new_src;
        act_last <= new_last;
        act_mode <= cur_mode;
      end
      if (act_chg) cnt_q <= 4'd0;
      else if (tick) cnt_q <= (cnt_q == act_last) ? 4'd0 : cnt_q + 4'd1;
    end
  end

  assign cpu_ce = tick && (cnt_q == act_last);
  assign mode   = act_mode;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {2'b00, fld_q, d8_eff, osc_q, off_q, sub_q};
      2'd1:    rd_data = {stab_q, sdet_q, drv_eff};
      2'd2:    rd_data = {7'd0, err_q};
      default: rd_data = {4'd0, pfast_q, pwait_q, psel_q, pen_q};
    endcase
  end
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       main_tick,
  input logic       sub_tick,
  input logic       ring_tick,
  input logic       pll_tick,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [1:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       cpu_ce,
  input logic [2:0] mode,
  input logic [2:0] cur_mode,
  input logic       err_q,
  input logic       sub_q,
  input logic       off_q,
  input logic       osc_q,
  input logic [1:0] fld_q,
  input logic       pen_q,
  input logic       psel_q,
  input logic       pwait_q,
  input logic       pfast_q,
  input logic       stab_busy,
  input logic       need_main
);
  p_ce_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> (main_tick || sub_tick || ring_tick || pll_tick));

  p_mode_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 3'd7);

  p_pll_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 3'd2 && $past(cur_mode) != 3'd2) |-> $past(cur_mode) == 3'd0);

  p_pll_leave_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != 3'd2 && $past(cur_mode) == 3'd2) |-> cur_mode == 3'd0);

  p_force_div8_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0 && !osc_q && off_q) |-> rd_data[3]);

  p_wait_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_q && $past(pen_q)) |-> pwait_q == $past(pwait_q));

  p_refused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $stable({sub_q, off_q, osc_q, fld_q, pen_q, psel_q, pwait_q, pfast_q}));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_en && wr_addr == 2'd2 && wr_data[0])) |=> err_q);

  p_stab_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stab_busy && need_main) |=> $stable(mode));
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
  .ring_tick(ring_tick), .pll_tick(pll_tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cpu_ce(cpu_ce),
  .mode(mode), .cur_mode(cur_mode), .err_q(err_q), .sub_q(sub_q), .off_q(off_q),
  .osc_q(osc_q), .fld_q(fld_q), .pen_q(pen_q), .psel_q(psel_q), .pwait_q(pwait_q),
  .pfast_q(pfast_q), .stab_busy(stab_busy), .need_main(need_main)
);

// File: tb/clk_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_mode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       main_tick = 1'b0, sub_tick = 1'b0, ring_tick = 1'b0, pll_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       cpu_ce;
  logic [2:0] mode;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int pending = 0;

  typedef struct {
    int    kind;
    int    arg;
    int    exp;
    string tag;
  } item_t;
  item_t sbq[$];

  clk_mode_ctrl #(.STAB_RST(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
    .ring_tick(ring_tick), .pll_tick(pll_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cpu_ce(cpu_ce), .mode(mode)
  );

  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      main_tick = (cyc % 2 == 0);
      sub_tick  = (cyc % 7 == 0);
      ring_tick = (cyc % 3 == 0);
      pll_tick  = 1'b1;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin : mon
      item_t it;
      int t0;
      int dv;
      @(negedge clk);
      if (sbq.size() != 0) begin
        it = sbq.pop_front();
        if (it.kind == 0) begin
          rd_addr = it.arg[1:0];
          #0.5;
          check(it.tag, int'(rd_data), it.exp);
        end else if (it.kind == 1) begin
          check(it.tag, int'(mode), it.exp);
        end else begin
          t0 = -1;
          dv = -1;
          for (int k = 0; k < 400; k++) begin
            if (cpu_ce) begin
              if (t0 < 0) t0 = k;
              else begin
                dv = k - t0;
                break;
              end
            end
            @(negedge clk);
          end
          check(it.tag, dv, it.exp);
        end
        pending--;
      end
    end
  end

  task automatic push(int kind, int arg, int exp, string tag);
    item_t it;
    it.kind = kind; it.arg = arg; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    pending++;
    wait (pending == 0);
  endtask

  task automatic exp_rd(int a, int e, string tag);  push(0, a, e, tag); endtask
  task automatic exp_mode(int e, string tag);       push(1, 0, e, tag); endtask
  task automatic exp_rate(int e, string tag);       push(2, 0, e, tag); endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic clr_err();
    wr(2, 1);
    exp_rd(2, 0, "R11 error cleared by writing one");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    settle(3);
    exp_mode(1, "R1 reset mode");
    exp_rd(0, 8'h08, "R1 reset selection register");
    exp_rd(1, 8'h21, "R1 reset auxiliary register");
    exp_rd(2, 0, "R1 reset status");
    exp_rd(3, 8'h04, "R1 reset PLL register");
    exp_rate(16, "R1 reset rate main/8");

    wr(0, 8'h10);
    exp_rd(0, 8'h18, "R10 field first, divide-by-8 still old");
    exp_rd(0, 8'h10, "R10 divide-by-8 one cycle later");
    settle(4);
    exp_mode(1, "R2 main /2 mode");
    exp_rate(4, "R2 main /2 rate");
    wr(0, 8'h20); settle(4);
    exp_rate(8, "R2 main /4 rate");
    wr(0, 8'h30); settle(4);
    exp_rate(32, "R2 main /16 rate");
    wr(0, 8'h38); settle(4);
    exp_rate(16, "R2 divide-by-8 overrides field");
    wr(0, 8'h00);
    exp_rd(0, 8'h08, "R10 split toward high-speed, field first");
    exp_rd(0, 8'h00, "R10 split toward high-speed, second step");
    settle(4);
    exp_mode(0, "R2 high-speed mode");
    exp_rate(2, "R2 main /1 rate");

    wr(3, 8'h07); settle(4);
    exp_mode(2, "R5 PLL mode");
    exp_rate(1, "R5 PLL rate");
    wr(0, 8'h01); settle(3);
    exp_rd(2, 1, "R5 leaving PLL to low-speed refused");
    exp_rd(0, 8'h00, "R11 refused write leaves selection");
    exp_mode(2, "R5 still PLL");
    clr_err();
    wr(3, 8'h03); settle(2);
    exp_rd(2, 1, "R9 wait bit change with PLL on refused");
    exp_rd(3, 8'h07, "R9 PLL register unchanged");
    clr_err();
    wr(3, 8'h04); settle(4);
    exp_mode(0, "R5 PLL left to high-speed");
    wr(0, 8'h02); settle(2);
    exp_rd(2, 1, "R11 stopping main while it feeds CPU refused");
    exp_rd(0, 8'h00, "R11 selection unchanged");
    clr_err();
    wr(3, 8'h0F); settle(2);
    exp_rd(2, 1, "R9 fast PLL on with one wait refused");
    exp_rd(3, 8'h04, "R9 PLL register unchanged after refusal");
    clr_err();
    wr(3, 8'h0B); settle(4);
    exp_rd(2, 0, "R9 fast PLL on with two waits accepted");
    exp_mode(2, "R9 PLL mode entered");
    wr(3, 8'h08); settle(4);
    exp_mode(0, "R5 back to high-speed");
    wr(0, 8'h10); settle(4);
    exp_mode(1, "R2 medium before PLL attempt");
    wr(3, 8'h0B); settle(2);
    exp_rd(2, 1, "R5 PLL entry from medium refused");
    exp_rd(3, 8'h08, "R5 PLL register unchanged");
    clr_err();

    wr(1, 8'h22); settle(2);
    wr(0, 8'h20); settle(4);
    exp_rd(2, 0, "R6 ratio change within mode accepted");
    exp_rate(8, "R6 new ratio applied");
    wr(0, 8'h01); settle(2);
    exp_rd(2, 1, "R6 mode change refused with stop-detect on");
    exp_rd(0, 8'h20, "R6 selection unchanged");
    clr_err();
    wr(1, 8'hA0); settle(2);
    exp_rd(1, 8'hA0, "R8 drive not forced while main runs");

    wr(0, 8'h21); settle(4);
    exp_mode(3, "R3 low-speed mode");
    exp_rate(7, "R3 sub clock undivided");
    wr(0, 8'h23); settle(4);
    exp_mode(4, "R3 low-power mode");
    exp_rd(0, 8'h2B, "R8 divide-by-8 forced");
    exp_rd(1, 8'hA1, "R8 drive forced");
    exp_rate(7, "R3 sub clock in low-power");

    wr(0, 8'h20); settle(2);
    exp_mode(4, "R12 old mode during stabilisation");
    exp_rate(7, "R12 old source during stabilisation");
    exp_mode(4, "R12 still waiting");
    settle(100);
    exp_mode(1, "R12 main selection after wait");
    exp_rate(8, "R12 main /4 after wait");

    wr(0, 8'h24); settle(4);
    exp_mode(5, "R4 on-chip mode");
    exp_rate(12, "R4 on-chip /4");
    wr(0, 8'h20); settle(2);
    exp_rd(2, 1, "R7 exit without divide-by-8 refused");
    exp_mode(5, "R7 mode unchanged");
    clr_err();
    wr(0, 8'h2C); settle(4);
    exp_rate(24, "R4 on-chip /8");
    wr(0, 8'h2E); settle(4);
    exp_mode(6, "R4 on-chip low-power mode");
    exp_rd(0, 8'h2E, "R8 no forcing with on-chip on");
    wr(0, 8'h28); settle(2);
    exp_rd(2, 0, "R7 exit with divide-by-8 accepted");
    exp_mode(6, "R12 on-chip stays during wait");
    settle(100);
    exp_mode(1, "R12 main after wait from on-chip");
    exp_rate(16, "R7 main /8 after exit");

    settle(5);
    finish_run();
  end
endmodule